// File: doc/BRIEF.md
# Variable-Aspect Synchronous FIFO

This block is a single-clock first-in first-out buffer over a 4,608-bit storage array. The producer side and the consumer side each have their own data width. The widths come from two groups: 1, 2 or 4 bits, or 9 and 18 bits. The two sides may differ only within one group. Data pushed as wide words can be popped as narrower pieces, and narrow pieces pushed one after another can be popped as one wide word. Internal counters produce the write and read locations, so the user only drives enables and data.

The block keeps an occupancy count in units of the narrower of the two widths. It reports full, empty, almost-full and almost-empty. The two almost thresholds are given at input ports, in the same narrow units. The 4-bit group uses 4,096 bits of the array (4,096 one-bit units). The 9/18 group uses all 4,608 bits (512 nine-bit units). The 9th and 18th bits are ordinary data.

Top module: `vafifo_top`

## Requirements
- R1: A synchronous active-low reset clears the pointers and the occupancy. In the cycle after the reset edge, empty and almost_empty are 1, full and almost_full are 0, and rd_data is 0.
- R2: Units leave in the order they entered. When a narrow read takes from a wide word, read k of that word returns bits [k*RD_W +: RD_W], starting with k = 0. A narrow write k into a wide word fills the same bit slice. rd_data changes on the clock edge that accepts the read and holds until the next accepted read.
- R3: Occupancy counts narrow units. An accepted write adds WR_W/min(WR_W,RD_W) units. An accepted read removes RD_W/min(WR_W,RD_W) units.
- R4: full is 1 exactly when occupancy plus the write size in units exceeds the capacity in units. A write while full is ignored: no data is stored and occupancy is unchanged.
- R5: empty is 1 exactly when occupancy is below the read size in units. A read while empty is ignored: occupancy is unchanged and rd_data holds its value.
- R6: almost_full is 1 when occupancy is at or above af_level.
- R7: almost_empty is 1 when occupancy is at or below ae_level.
- R8: All four flags are registered. Each reflects the occupancy reached after a clock edge, from the cycle that follows that edge. Flag values already account for a write and a read accepted on the same edge.
- R9: The pointers wrap modulo the capacity. Ordering and data are preserved across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push request, taken when full is 0 |
| wr_data | input | WR_W | Data pushed |
| rd_en | input | 1 | Pop request, taken when empty is 0 |
| rd_data | output | RD_W | Registered data of the last accepted pop |
| af_level | input | LW | Almost-full threshold in narrow units |
| ae_level | input | LW | Almost-empty threshold in narrow units |
| full | output | 1 | No room for one more write |
| empty | output | 1 | Not enough data for one read |
| almost_full | output | 1 | Occupancy at or above af_level |
| almost_empty | output | 1 | Occupancy at or below ae_level |

## Verification
The bench builds the block with its defaults: 4-bit writes and 1-bit reads. This gives a capacity of 4,096 one-bit units and a width ratio of four. Least-significant-first slicing and the full band between 4,093 and 4,096 units are therefore reachable, and a single read does not clear full. The thresholds are moved between a high pair near capacity and a low pair of a few units. Each flag's equality boundary is crossed by both directed and random traffic. Several passes over the whole capacity exercise pointer wrap.

// File: rtl/vafifo_pkg.sv
// Package: width arithmetic shared by the FIFO parts.
// Assumes: widths are 1, 2, 4 (bit group) or 9, 18 (byte group).
package vafifo_pkg;

    // Narrower of two port widths: the unit of occupancy.
    function automatic int narrow_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // Wider of two port widths: the width of one storage word.
    function automatic int wide_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Usable bits of the array for the width group of w.
    function automatic int family_bits(input int total, input int w);
        return (w % 9 == 0) ? total : (total / 9) * 8;
    endfunction

endpackage

// File: rtl/vafifo_ptrs.sv
// Module: write/read pointers and occupancy counter, all in narrow units.
// Assumes: CAP is a power of two, so the pointers wrap naturally.
module vafifo_ptrs #(
    parameter int PW = 12,
    parameter int WU = 4,
    parameter int RU = 1,
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ok,
    input  logic          rd_ok,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic [CW-1:0] cnt_nxt
);

    logic [CW-1:0] cnt_q;

    // Occupancy after this edge: add write units, remove read units.
    always_comb begin
        cnt_nxt = cnt_q;
        if (wr_ok) cnt_nxt = cnt_nxt + CW'(WU);
        if (rd_ok) cnt_nxt = cnt_nxt - CW'(RU);
    end

    // Advance the pointers and store the new occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + PW'(WU);
            if (rd_ok) rptr <= rptr + PW'(RU);
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/vafifo_store.sv
// Module: storage array of wide words with slice writes and slice reads.
// Assumes: sel inputs are zero on the wide side; narrow slices are
// placed least significant first; rd_data is registered.
module vafifo_store #(
    parameter int MAXW  = 4,
    parameter int MINW  = 1,
    parameter int WR_W  = 4,
    parameter int RD_W  = 1,
    parameter int DEPTH = 1024,
    parameter int SW    = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ok,
    input  logic [AW-1:0]   waddr,
    input  logic [SW-1:0]   wsel,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_ok,
    input  logic [AW-1:0]   raddr,
    input  logic [SW-1:0]   rsel,
    output logic [RD_W-1:0] rd_data
);

    logic [MAXW-1:0] mem [DEPTH];
    logic [MAXW-1:0] wmask;
    logic [MAXW-1:0] wword;
    logic [MAXW-1:0] rword;
    int              wsh;
    int              rsh;

    // Place the incoming data and its mask at the selected slice.
    always_comb begin
        wsh   = int'(wsel) * MINW;
        wmask = MAXW'({WR_W{1'b1}}) << wsh;
        wword = MAXW'(wr_data) << wsh;
    end

    // Pick the requested slice from the addressed word.
    always_comb begin
        rsh   = int'(rsel) * MINW;
        rword = mem[raddr] >> rsh;
    end

    // Merge the written slice into its word.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[waddr] <= (mem[waddr] & ~wmask) | (wword & wmask);
    end

    // Register the read data when a read is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_ok) rd_data <= rword[RD_W-1:0];
    end

endmodule

// File: rtl/vafifo_flags.sv
// Module: registered status flags computed from the next occupancy.
// Assumes: thresholds are in narrow units and the same width as the count.
module vafifo_flags #(
    parameter int CW  = 13,
    parameter int CAP = 4096,
    parameter int WU  = 4,
    parameter int RU  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [CW-1:0] af_level,
    input  logic [CW-1:0] ae_level,
    output logic          full,
    output logic          empty,
    output logic          almost_full,
    output logic          almost_empty
);

    logic full_d, empty_d, af_d, ae_d;

    // Decode the occupancy the edge is about to store.
    always_comb begin
        full_d  = ({1'b0, cnt_nxt} + (CW+1)'(WU)) > (CW+1)'(CAP);
        empty_d = cnt_nxt < CW'(RU);
        af_d    = cnt_nxt >= af_level;
        ae_d    = cnt_nxt <= ae_level;
    end

    // Hold the flags in registers, empty-side set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full         <= 1'b0;
            empty        <= 1'b1;
            almost_full  <= 1'b0;
            almost_empty <= 1'b1;
        end else begin
            full         <= full_d;
            empty        <= empty_d;
            almost_full  <= af_d;
            almost_empty <= ae_d;
        end
    end

endmodule

// File: rtl/vafifo_top.sv
// Module: variable-aspect synchronous FIFO over one 4,608-bit array.
// Assumes: WR_W and RD_W are in the same width group (1/2/4 or 9/18),
// one clock for both sides, thresholds given in narrow units.
module vafifo_top #(
    parameter int  TOTAL_BITS = 4608,
    parameter int  WR_W       = 4,
    parameter int  RD_W       = 1,
    localparam int MINW  = vafifo_pkg::narrow_of(WR_W, RD_W),
    localparam int MAXW  = vafifo_pkg::wide_of(WR_W, RD_W),
    localparam int FAMB  = vafifo_pkg::family_bits(TOTAL_BITS, MAXW),
    localparam int RATIO = MAXW / MINW,
    localparam int RB    = $clog2(RATIO),
    localparam int WU    = WR_W / MINW,
    localparam int RU    = RD_W / MINW,
    localparam int CAP   = FAMB / MINW,
    localparam int DEPTH = FAMB / MAXW,
    localparam int PW    = $clog2(CAP),
    localparam int AW    = PW - RB,
    localparam int SW    = (RB > 0) ? RB : 1,
    localparam int LW    = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    input  logic [LW-1:0]   af_level,
    input  logic [LW-1:0]   ae_level,
    output logic            full,
    output logic            empty,
    output logic            almost_full,
    output logic            almost_empty
);

    logic          wr_ok, rd_ok;
    logic [PW-1:0] wptr, rptr;
    logic [LW-1:0] cnt_nxt;
    logic [AW-1:0] waddr, raddr;
    logic [SW-1:0] wsel, rsel;

    // Accept only operations the registered flags allow.
    always_comb begin
        wr_ok = wr_en & ~full;
        rd_ok = rd_en & ~empty;
    end

    // Word address is the pointer above the slice bits.
    assign waddr = wptr[PW-1:RB];
    assign raddr = rptr[PW-1:RB];

    // Slice select exists only when the two widths differ.
    generate
        if (RB == 0) begin : g_same_width
            assign wsel = '0;
            assign rsel = '0;
        end else begin : g_split_width
            assign wsel = wptr[RB-1:0];
            assign rsel = rptr[RB-1:0];
        end
    endgenerate

    vafifo_ptrs #(.PW(PW), .WU(WU), .RU(RU)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .wptr    (wptr),
        .rptr    (rptr),
        .cnt_nxt (cnt_nxt)
    );

    vafifo_store #(
        .MAXW(MAXW), .MINW(MINW), .WR_W(WR_W), .RD_W(RD_W),
        .DEPTH(DEPTH), .SW(SW)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_ok),
        .waddr   (waddr),
        .wsel    (wsel),
        .wr_data (wr_data),
        .rd_ok   (rd_ok),
        .raddr   (raddr),
        .rsel    (rsel),
        .rd_data (rd_data)
    );

    vafifo_flags #(.CW(LW), .CAP(CAP), .WU(WU), .RU(RU)) flag_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_nxt      (cnt_nxt),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

endmodule

// File: rtl/vafifo_chk.sv
// Module: protocol checker for vafifo_top, attached by bind.
// Assumes: observes only the ports of the FIFO.
module vafifo_chk #(
    parameter int RD_W = 1,
    parameter int LW   = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_data,
    input logic [LW-1:0]   af_level,
    input logic [LW-1:0]   ae_level,
    input logic            full,
    input logic            empty,
    input logic            almost_full,
    input logic            almost_empty
);

    logic seen_q     = 1'b0;
    logic rst_prev_q = 1'b1;

    // Check the state left by a reset edge one cycle later.
    always @(posedge clk) begin
        if (seen_q && !rst_prev_q) begin
            // R1
            reset_state_chk: assert (empty && almost_empty && !full && !almost_full && rd_data == '0);
        end
        seen_q     <= 1'b1;
        rst_prev_q <= rst_n;
    end

    // R4
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !empty) |=> $stable(rd_data));

    // R4
    full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !(rd_en && !empty)) |=> full);

    // R5
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !(wr_en && !full)) |=> empty);

    // R6
    afull_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (almost_full && wr_en && !full && !rd_en && $stable(af_level)) |=> almost_full);

    // R7
    aempty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (almost_empty && rd_en && !empty && !wr_en && $stable(ae_level)) |=> almost_empty);

endmodule

bind vafifo_top vafifo_chk #(.RD_W(RD_W), .LW(LW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .af_level     (af_level),
    .ae_level     (ae_level),
    .full         (full),
    .empty        (empty),
    .almost_full  (almost_full),
    .almost_empty (almost_empty)
);

// File: tb/vafifo_top_tb_top.sv
// Bench: queue-based reference model compared with the FIFO every cycle.
module vafifo_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WR_W       = 4;
    localparam int RD_W       = 1;
    localparam int UW         = 1;     // narrow unit width
    localparam int WU         = 4;     // units per write
    localparam int RU         = 1;     // units per read
    localparam int UNITS_CAP  = 4096;  // bit group uses 4,096 bits
    localparam int LW         = 13;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en, rd_en;
    logic [WR_W-1:0] wr_data;
    logic [RD_W-1:0] rd_data;
    logic [LW-1:0]   af_level, ae_level;
    logic            full, empty, almost_full, almost_empty;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    logic [UW-1:0]   mq [$];
    logic [RD_W-1:0] m_rd  = '0;
    bit              m_full  = 1'b0;
    bit              m_empty = 1'b1;
    bit              m_af    = 1'b0;
    bit              m_ae    = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    vafifo_top #(.WR_W(WR_W), .RD_W(RD_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .af_level     (af_level),
        .ae_level     (ae_level),
        .full         (full),
        .empty        (empty),
        .almost_full  (almost_full),
        .almost_empty (almost_empty)
    );

    task automatic check(input string req, input string ph, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, ph, $time, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, compare at negedge.
    task automatic step(input bit w, input logic [WR_W-1:0] d, input bit r, input string ph);
        bit wok, rok;
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        if (!rst_n) begin
            mq.delete();
            m_rd = '0; m_full = 1'b0; m_empty = 1'b1; m_af = 1'b0; m_ae = 1'b1;
        end else begin
            wok = w && !m_full;
            rok = r && !m_empty;
            if (rok) for (int i = 0; i < RU; i++) m_rd[i*UW +: UW] = mq.pop_front();
            if (wok) for (int i = 0; i < WU; i++) mq.push_back(d[i*UW +: UW]);
            m_full  = (mq.size() + WU) > UNITS_CAP;
            m_empty = mq.size() < RU;
            m_af    = mq.size() >= int'(af_level);
            m_ae    = mq.size() <= int'(ae_level);
        end
        @(negedge clk);
        check("R4", ph, int'(full), int'(m_full));
        check("R5", ph, int'(empty), int'(m_empty));
        check("R6", ph, int'(almost_full), int'(m_af));
        check("R7", ph, int'(almost_empty), int'(m_ae));
        check("R2", ph, int'(rd_data), int'(m_rd));
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        af_level = 13'd4092; ae_level = 13'd4;
        repeat (3) step(0, '0, 0, "R1 reset held");
        rst_n = 1'b1;
        step(0, '0, 0, "R1 after reset");
        check("R1", "reset values", int'({full, empty, almost_full, almost_empty}), 4'b0101);

        // R3: one 4-bit write is four units; 4 <= ae 4 keeps almost_empty.
        step(1, 4'hA, 0, "R3 wide write");
        check("R3", "4 units at ae=4", int'(almost_empty), 1);
        ae_level = 13'd3;
        step(0, '0, 0, "R3 threshold 3");
        check("R3", "4 units at ae=3", int'(almost_empty), 0);

        // R2: 4'b1010 leaves bit 0 first.
        step(0, '0, 1, "R2 slice0"); check("R2", "slice 0", int'(rd_data), 0);
        step(0, '0, 1, "R2 slice1"); check("R2", "slice 1", int'(rd_data), 1);
        step(0, '0, 1, "R2 slice2"); check("R2", "slice 2", int'(rd_data), 0);
        step(0, '0, 1, "R2 slice3"); check("R2", "slice 3", int'(rd_data), 1);

        // R5: reads while empty are ignored and rd_data holds.
        step(0, '0, 1, "R5 read empty");
        step(0, '0, 1, "R5 read empty");
        check("R5", "hold after empty read", int'(rd_data), 1);

        // R8: push and pop on one edge.
        step(1, 4'h6, 0, "R8 prime");
        step(1, 4'h9, 1, "R8 both");
        step(1, 4'h3, 1, "R8 both");
        for (int i = 0; i < 11; i++) step(0, '0, 1, "R8 drain");
        check("R8", "empty after drain", int'(empty), 1);

        // R4: fill to capacity, extra writes ignored, release boundary.
        for (int i = 0; i < 1030; i++) step(1, 4'(i * 7 + 3), 0, "R4 fill");
        check("R4", "full at capacity", int'(full), 1);
        step(1, 4'hF, 0, "R4 write while full");
        step(0, '0, 1, "R4 4095 units");
        check("R4", "still full at 4095", int'(full), 1);
        step(1, 4'hF, 0, "R4 write while full");
        repeat (3) step(0, '0, 1, "R4 release");
        check("R4", "open at 4092", int'(full), 0);

        // R9: drain everything, data checked past the wrap.
        for (int i = 0; i < 4100; i++) step(0, '0, 1, "R9 drain");
        check("R9", "empty after full pass", int'(empty), 1);

        // R6/R7 low thresholds under low-occupancy traffic.
        af_level = 13'd8; ae_level = 13'd5;
        for (int i = 0; i < 3000; i++)
            step($urandom_range(3) == 0, 4'($urandom), 1'b1, "R6 R7 low band");

        // R9 heavy traffic across several wraps.
        af_level = 13'd4000; ae_level = 13'd100;
        for (int i = 0; i < 4000; i++)
            step($urandom_range(1) == 0, 4'($urandom), $urandom_range(1) == 0, "R9 heavy");
        for (int i = 0; i < 6000; i++)
            step($urandom_range(7) == 0, 4'($urandom), 1'b1, "R9 unwind");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

endmodule